// File: doc/BRIEF.md
# Flat Page Table Walker

This block turns a virtual address into a physical address by fetching a single page table entry from memory. A base register holds the physical address where a flat page table starts. The walker uses the virtual page number (the address bits above the 4 KiB page offset) as an index into that table, issues one read on a valid/ready memory port, and waits for the reply. The page offset bits pass through unchanged.

When the returned entry is marked present and the memory reply carries no error, the walker reports the physical address together with the referenced, dirty and writable bits of the entry. When the entry is not present, or the memory flags an error, it reports a fault and returns neither a physical address nor status bits. Fault servicing, multi-level tables and write-back of status bits are left to other logic.

The controller has four states. IDLE accepts a request and latches the virtual address (IDLE to REQ). REQ holds the read request until memory takes it (REQ to WAIT). WAIT takes the reply when it arrives (WAIT to DONE). DONE presents the result for one cycle and returns unconditionally (DONE to IDLE).

Top module: `pt_walker`

## Requirements
- R1: After reset the walker is in IDLE: `req_ready` is 1, `mem_req_valid`, `done` and `fault` are 0, and the base register holds the `BASE_RST` parameter value.
- R2: The read address is the base register plus the virtual page number (`req_vaddr` bits above `PAGE_SHIFT`) shifted left by 2, truncated to `PA_W` bits, and it stays stable while `mem_req_valid` is 1 and `mem_req_ready` is 0.
- R3: Each accepted request produces exactly one read: `mem_req_valid` drops in the cycle after the handshake and stays low until the next request.
- R4: For a present entry (bit 0 = 1) with no error, `paddr` is the entry's frame number (bits from 12 upward, `PA_W-12` of them) followed by the untouched low 12 bits of the virtual address, and `fault` is 0.
- R5: With a successful translation, `pte_referenced`, `pte_dirty` and `pte_writable` equal entry bits 1, 2 and 3.
- R6: An entry with bit 0 clear gives `fault` = 1 with `paddr` and all three status outputs at 0.
- R7: A reply with `mem_rsp_err` = 1 gives a fault, whatever the entry says.
- R8: `done` is a single-cycle pulse in the cycle after the reply is taken; `fault` is only ever 1 together with `done`.
- R9: A base write takes effect only while the walker is in IDLE; writes in REQ, WAIT or DONE leave the base unchanged.
- R10: `req_ready` is 1 only in IDLE; a request presented while busy is neither accepted nor queued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_base_we | input | 1 | Base register write strobe |
| cfg_base_wdata | input | PA_W | New table base address |
| req_valid | input | 1 | Translation request |
| req_ready | output | 1 | Walker idle and taking a request |
| req_vaddr | input | VA_W | Virtual address to translate |
| mem_req_valid | output | 1 | Entry read request |
| mem_req_ready | input | 1 | Memory takes the read |
| mem_req_addr | output | PA_W | Entry physical address |
| mem_rsp_valid | input | 1 | Read reply present |
| mem_rsp_data | input | PTE_W | Returned table entry |
| mem_rsp_err | input | 1 | Read reply carries an error |
| done | output | 1 | One-cycle result strobe |
| fault | output | 1 | Translation failed |
| paddr | output | PA_W | Translated physical address |
| pte_referenced | output | 1 | Entry referenced bit |
| pte_dirty | output | 1 | Entry dirty bit |
| pte_writable | output | 1 | Entry writable bit |

## Verification
The bench builds the walker with 16-bit virtual and physical addresses, which leaves a 4-bit page number and a 4-bit frame number. That makes every one of the 16 table indices reachable and lets each be paired with all 16 combinations of the four low entry bits, under two different base values and varying memory delays. Error replies and base writes or extra requests during a walk are mixed into the sweep, so the effect of each on the next address or result shows at the ports.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_REQ  = 2'd1,
        ST_WAIT = 2'd2,
        ST_DONE = 2'd3
    } ptw_state_e;

    // entry bit positions
    localparam int unsigned PTE_PRESENT_BIT = 0;
    localparam int unsigned PTE_REF_BIT     = 1;
    localparam int unsigned PTE_DIRTY_BIT   = 2;
    localparam int unsigned PTE_WR_BIT      = 3;
    localparam int unsigned PTE_PPN_LSB     = 12;

    typedef struct packed {
        logic writable;
        logic dirty;
        logic referenced;
    } ptw_flags_t;

endpackage

// File: rtl/ptw_base_reg.sv
module ptw_base_reg #(
    parameter int unsigned PA_W = 32,
    parameter logic [PA_W-1:0] RST_VAL = '0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [PA_W-1:0] wr_data,
    input  logic            idle,
    output logic [PA_W-1:0] base_q
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= RST_VAL;
        end else if (wr_en && idle) begin
            base_q <= wr_data;
        end
    end

endmodule

// File: rtl/ptw_addr_gen.sv
module ptw_addr_gen #(
    parameter int unsigned VPN_W       = 20,
    parameter int unsigned PA_W        = 32,
    parameter int unsigned ENTRY_SHIFT = 2
) (
    input  logic [PA_W-1:0]  base,
    input  logic [VPN_W-1:0] vpn,
    output logic [PA_W-1:0]  entry_addr
);

    logic [PA_W-1:0] index_ext;

    always_comb begin
        index_ext  = PA_W'(vpn) << ENTRY_SHIFT;
        entry_addr = base + index_ext;
    end

endmodule

// File: rtl/ptw_entry_dec.sv
module ptw_entry_dec
    import ptw_pkg::*;
#(
    parameter int unsigned PTE_W = 32,
    parameter int unsigned PPN_W = 20
) (
    input  logic [PTE_W-1:0] pte,
    input  logic             rsp_err,
    output logic             fault,
    output logic [PPN_W-1:0] ppn,
    output ptw_flags_t       flags
);

    localparam int unsigned PPN_TOP = PTE_PPN_LSB + PPN_W;

    logic unused_mid;
    logic unused_hi;

    always_comb begin
        fault            = rsp_err || !pte[PTE_PRESENT_BIT];
        ppn              = pte[PTE_PPN_LSB +: PPN_W];
        flags.referenced = pte[PTE_REF_BIT];
        flags.dirty      = pte[PTE_DIRTY_BIT];
        flags.writable   = pte[PTE_WR_BIT];
        unused_mid       = ^pte[PTE_PPN_LSB-1:PTE_WR_BIT+1];
    end

    generate
        if (PPN_TOP < PTE_W) begin : g_spare_hi
            assign unused_hi = ^pte[PTE_W-1:PPN_TOP];
        end else begin : g_full_hi
            assign unused_hi = 1'b0;
        end
    endgenerate

endmodule

// File: rtl/pt_walker.sv
module pt_walker
    import ptw_pkg::*;
#(
    parameter int unsigned VA_W       = 32,
    parameter int unsigned PA_W       = 32,
    parameter int unsigned PAGE_SHIFT = 12,
    parameter int unsigned PTE_W      = 32,
    parameter logic [PA_W-1:0] BASE_RST = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_base_we,
    input  logic [PA_W-1:0]  cfg_base_wdata,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [VA_W-1:0]  req_vaddr,
    output logic             mem_req_valid,
    input  logic             mem_req_ready,
    output logic [PA_W-1:0]  mem_req_addr,
    input  logic             mem_rsp_valid,
    input  logic [PTE_W-1:0] mem_rsp_data,
    input  logic             mem_rsp_err,
    output logic             done,
    output logic             fault,
    output logic [PA_W-1:0]  paddr,
    output logic             pte_referenced,
    output logic             pte_dirty,
    output logic             pte_writable
);

    localparam int unsigned VPN_W       = VA_W - PAGE_SHIFT;
    localparam int unsigned PPN_W       = PA_W - PAGE_SHIFT;
    localparam int unsigned ENTRY_SHIFT = $clog2(PTE_W / 8);

    ptw_state_e        state_q, state_d;
    logic [VA_W-1:0]   vaddr_q;
    logic [PTE_W-1:0]  pte_q;
    logic              err_q;
    logic [PA_W-1:0]   base_q;
    logic              dec_fault;
    logic [PPN_W-1:0]  dec_ppn;
    ptw_flags_t        dec_flags;
    logic              in_idle;

    assign in_idle = (state_q == ST_IDLE);

    ptw_base_reg #(
        .PA_W    (PA_W),
        .RST_VAL (BASE_RST)
    ) u_base (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cfg_base_we),
        .wr_data (cfg_base_wdata),
        .idle    (in_idle),
        .base_q  (base_q)
    );

    ptw_addr_gen #(
        .VPN_W       (VPN_W),
        .PA_W        (PA_W),
        .ENTRY_SHIFT (ENTRY_SHIFT)
    ) u_addr (
        .base       (base_q),
        .vpn        (vaddr_q[VA_W-1:PAGE_SHIFT]),
        .entry_addr (mem_req_addr)
    );

    ptw_entry_dec #(
        .PTE_W (PTE_W),
        .PPN_W (PPN_W)
    ) u_dec (
        .pte     (pte_q),
        .rsp_err (err_q),
        .fault   (dec_fault),
        .ppn     (dec_ppn),
        .flags   (dec_flags)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // captured request and reply
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vaddr_q <= '0;
            pte_q   <= '0;
            err_q   <= 1'b0;
        end else begin
            if (state_q == ST_IDLE && req_valid) begin
                vaddr_q <= req_vaddr;
            end
            if (state_q == ST_WAIT && mem_rsp_valid) begin
                pte_q <= mem_rsp_data;
                err_q <= mem_rsp_err;
            end
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (req_valid)     state_d = ST_REQ;
            ST_REQ:  if (mem_req_ready) state_d = ST_WAIT;
            ST_WAIT: if (mem_rsp_valid) state_d = ST_DONE;
            ST_DONE:                    state_d = ST_IDLE;
            default:                    state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        req_ready      = 1'b0;
        mem_req_valid  = 1'b0;
        done           = 1'b0;
        fault          = 1'b0;
        paddr          = '0;
        pte_referenced = 1'b0;
        pte_dirty      = 1'b0;
        pte_writable   = 1'b0;
        unique case (state_q)
            ST_IDLE: req_ready     = 1'b1;
            ST_REQ:  mem_req_valid = 1'b1;
            ST_WAIT: ;
            ST_DONE: begin
                done  = 1'b1;
                fault = dec_fault;
                if (!dec_fault) begin
                    paddr          = {dec_ppn, vaddr_q[PAGE_SHIFT-1:0]};
                    pte_referenced = dec_flags.referenced;
                    pte_dirty      = dec_flags.dirty;
                    pte_writable   = dec_flags.writable;
                end
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/ptw_chk.sv
module ptw_chk
    import ptw_pkg::*;
#(
    parameter int unsigned PA_W = 32
) (
    input logic            clk,
    input logic            rst_n,
    input ptw_state_e      state_q,
    input logic            req_ready,
    input logic            mem_req_valid,
    input logic            mem_req_ready,
    input logic [PA_W-1:0] mem_req_addr,
    input logic            mem_rsp_valid,
    input logic            mem_rsp_err,
    input logic            done,
    input logic            fault,
    input logic [PA_W-1:0] paddr,
    input logic            pte_referenced,
    input logic            pte_dirty,
    input logic            pte_writable
);

    // R2
    addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

    // R3
    single_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && mem_req_ready) |=> !mem_req_valid);

    // R6
    fault_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> (paddr == '0 && !pte_referenced && !pte_dirty && !pte_writable));

    // R7
    err_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAIT && mem_rsp_valid && mem_rsp_err) |=> (done && fault));

    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R8
    fault_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> done);

    // R10
    ready_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (!mem_req_valid && !done));

endmodule

bind pt_walker ptw_chk #(.PA_W(PA_W)) u_ptw_chk (.*);

// File: tb/test_pt_walker.sv
`timescale 1ns/1ps
module test_pt_walker;

    localparam int unsigned VA_W = 16;
    localparam int unsigned PA_W = 16;
    localparam int unsigned PAGE_SHIFT = 12;
    localparam int unsigned PTE_W = 32;
    localparam logic [PA_W-1:0] RST_BASE = 16'h0040;

    logic             clk;
    logic             rst_n;
    logic             cfg_base_we;
    logic [PA_W-1:0]  cfg_base_wdata;
    logic             req_valid;
    logic             req_ready;
    logic [VA_W-1:0]  req_vaddr;
    logic             mem_req_valid;
    logic             mem_req_ready;
    logic [PA_W-1:0]  mem_req_addr;
    logic             mem_rsp_valid;
    logic [PTE_W-1:0] mem_rsp_data;
    logic             mem_rsp_err;
    logic             done;
    logic             fault;
    logic [PA_W-1:0]  paddr;
    logic             pte_referenced;
    logic             pte_dirty;
    logic             pte_writable;

    int total = 0;
    int bad   = 0;

    pt_walker #(
        .VA_W       (VA_W),
        .PA_W       (PA_W),
        .PAGE_SHIFT (PAGE_SHIFT),
        .PTE_W      (PTE_W),
        .BASE_RST   (RST_BASE)
    ) i_pt_walker (.*);

    initial clk = 1'b0;
    always #10 clk = ~clk;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL R3 watchdog actual=hung expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    task automatic walk(input logic [VA_W-1:0] va, input logic [PTE_W-1:0] pte,
                        input logic err, input int rdly, input int sdly,
                        input logic [PA_W-1:0] base, input logic noise);
        logic [PA_W-1:0] exp_addr;
        logic            exp_fault;
        logic [PA_W-1:0] exp_pa;
        exp_addr  = base + (PA_W'(va[VA_W-1:PAGE_SHIFT]) << 2);
        exp_fault = err || !pte[0];
        exp_pa    = exp_fault ? '0 : {pte[12 +: PA_W-PAGE_SHIFT], va[PAGE_SHIFT-1:0]};

        @(negedge clk);
        chk("R10 ready in idle", {31'd0, req_ready}, 32'd1);
        req_valid = 1'b1;
        req_vaddr = va;
        @(negedge clk);
        // busy: extra request and base write must be ignored
        req_valid = noise;
        req_vaddr = ~va;
        cfg_base_we    = noise;
        cfg_base_wdata = 16'hDEAD;
        chk("R3 read issued", {31'd0, mem_req_valid}, 32'd1);
        chk("R2 entry address", {16'd0, mem_req_addr}, {16'd0, exp_addr});
        chk("R10 not ready when busy", {31'd0, req_ready}, 32'd0);
        for (int i = 0; i < rdly; i++) begin
            @(negedge clk);
            chk("R2 address held", {16'd0, mem_req_addr}, {16'd0, exp_addr});
            chk("R2 request held", {31'd0, mem_req_valid}, 32'd1);
        end
        mem_req_ready = 1'b1;
        @(negedge clk);
        mem_req_ready = 1'b0;
        chk("R3 request dropped", {31'd0, mem_req_valid}, 32'd0);
        for (int i = 0; i < sdly; i++) begin
            @(negedge clk);
            chk("R3 no second read", {31'd0, mem_req_valid}, 32'd0);
            chk("R8 no early done", {31'd0, done}, 32'd0);
        end
        mem_rsp_valid = 1'b1;
        mem_rsp_data  = pte;
        mem_rsp_err   = err;
        @(negedge clk);
        mem_rsp_valid = 1'b0;
        mem_rsp_err   = 1'b0;
        req_valid     = 1'b0;
        cfg_base_we   = 1'b0;
        chk("R8 done pulse", {31'd0, done}, 32'd1);
        chk(err ? "R7 error fault" : "R6 fault flag", {31'd0, fault}, {31'd0, exp_fault});
        chk(exp_fault ? "R6 no address" : "R4 physical address", {16'd0, paddr}, {16'd0, exp_pa});
        chk("R5 status bits", {29'd0, pte_writable, pte_dirty, pte_referenced},
            exp_fault ? 32'd0 : {29'd0, pte[3], pte[2], pte[1]});
        @(negedge clk);
        chk("R8 done single cycle", {31'd0, done}, 32'd0);
        chk("R10 back to idle", {31'd0, req_ready}, 32'd1);
    endtask

    initial begin
        logic [PA_W-1:0] bases [2];
        bases[0] = 16'h0100;
        bases[1] = 16'hBF00;
        rst_n = 1'b0;
        cfg_base_we = 1'b0;
        cfg_base_wdata = '0;
        req_valid = 1'b0;
        req_vaddr = '0;
        mem_req_ready = 1'b0;
        mem_rsp_valid = 1'b0;
        mem_rsp_data = '0;
        mem_rsp_err = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 reset ready", {31'd0, req_ready}, 32'd1);
        chk("R1 reset no read", {31'd0, mem_req_valid}, 32'd0);
        chk("R1 reset no done", {31'd0, done}, 32'd0);
        chk("R1 reset no fault", {31'd0, fault}, 32'd0);
        rst_n = 1'b1;

        // R1: reset base value used by the first walk
        walk(16'h3ABC, 32'h0000_5003, 1'b0, 1, 0, RST_BASE, 1'b0);

        for (int b = 0; b < 2; b++) begin
            // R9: base write while idle takes effect
            @(negedge clk);
            cfg_base_we = 1'b1;
            cfg_base_wdata = bases[b];
            @(negedge clk);
            cfg_base_we = 1'b0;
            for (int v = 0; v < 16; v++) begin
                for (int f = 0; f < 16; f++) begin
                    logic [3:0]      ppn;
                    logic [11:0]     off;
                    logic [PTE_W-1:0] pte;
                    ppn = 4'((v * 5 + f * 3 + b) & 15);
                    off = 12'((v * 37 + f * 101 + b * 7) & 12'hFFF);
                    pte = {16'hA5C3 ^ 16'(v * 17 + f), ppn, 8'(v * 9 + f) , 4'(f)};
                    walk({4'(v), off}, pte, ((v ^ f) == 9), (v + f) % 3, f % 3,
                         bases[b], (f == 6));
                end
            end
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule